// File: doc/BRIEF.md
# Fractional SPI Serial Clock and Strobe Generator

This block derives the serial clock of one SPI timing profile from a fast reference clock. The divider is a phase accumulator, not an integer counter. Every reference cycle it adds a 14-bit frequency word, so the serial clock runs at reference × word / 2048. A word of 2048 divided by the integer ratio gives a plain division. Other words give fractional rates, where each half period lasts either the floor or the ceiling of 1024/word reference cycles.

The block applies the clock polarity. It also issues two one-cycle strobes that the shift logic outside the block uses. The launch strobe marks when to drive the next output bit, and the sample strobe marks when to capture the input bit. Each strobe can be tied to the leading edge or to the trailing edge of the serial clock. Edges are counted relative to the idle level, which gives the four usual SPI modes. For high output rates, an asynchronous-capture option passes the serial input through a synchroniser and delays the sample strobe to match. A restart option zeroes the accumulator when a transfer begins, so the first clock phase does not depend on earlier transfers.

Top module: `spi_clk_profile_gen`

## Requirements
- R1: While reset is asserted, sclk equals cpol, launch_pulse and sample_pulse are 0 and rx_bit is 0.
- R2: With enable high, the 12-bit phase p (0 after reset) becomes base + freq_word modulo 4096 every reference cycle. Here base is p, or 0 under R5. sclk toggles after that cycle exactly when (base mod 1024) + freq_word ≥ 1024, so for freq_word below 1024 the full period averages 2048/freq_word cycles.
- R3: A freq_word of 1024 or more toggles sclk every reference cycle, which is the fastest possible rate (reference / 2).
- R4: While enable is low, sclk returns to and holds cpol one cycle later, no strobe is produced, and the phase p is held unchanged.
- R5: In the first enabled cycle after a disabled one, base is 0 if restart_loop is 1. If restart_loop is 0, base is the held phase p.
- R6: sclk equals cpol while idle. In the active phase, between a leading edge and the next trailing edge, sclk equals the inverse of cpol.
- R7: launch_pulse is high for the one cycle in which sclk first shows a new level. It follows the leading edge (leaving idle) when launch_rise is 1 and the trailing edge (returning to idle) when launch_rise is 0.
- R8: The sample edge follows the leading edge when latch_rise is 1 and the trailing edge when latch_rise is 0.
- R9: With async_in at 0, sample_pulse coincides with the selected sclk edge, and rx_bit loads the value of sdi present at that edge.
- R10: With async_in at 1, sample_pulse comes 2 reference cycles after the selected edge. At that moment rx_bit loads the last stage of a 2-flop synchroniser fed by sdi.
- R11: Each strobe is a single-cycle pulse per sclk edge. A strobe still pending in the 2-cycle delay is dropped when enable goes low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Transfer active; low holds sclk idle |
| freq_word | input | 14 | Phase increment per reference cycle |
| restart_loop | input | 1 | Zero the phase at each transfer start |
| cpol | input | 1 | Idle level of sclk |
| latch_rise | input | 1 | 1: sample on leading edge, 0: trailing |
| launch_rise | input | 1 | 1: launch on leading edge, 0: trailing |
| async_in | input | 1 | 1: resynchronise sdi and delay the sample strobe |
| sdi | input | 1 | Serial input data |
| sclk | output | 1 | Serial clock |
| launch_pulse | output | 1 | One-cycle launch strobe |
| sample_pulse | output | 1 | One-cycle sample strobe |
| rx_bit | output | 1 | Last captured input bit |

## Verification
The checker covers, on every cycle, the rules that hold whatever the stimulus:
- sclk stays idle with no strobes after a disabled cycle.
- The phase moves only on an accumulator tick, and on every cycle once the word reaches 1024.
- Each launch strobe lands on the edge direction its select asks for.
- A synchronous sample strobe sits on an edge.
- An asynchronous strobe trails the internal sample event by exactly two cycles.

The exact fractional spacing of the edges needs the bench's scenarios, which compare the outputs cycle by cycle against an independent accumulator model. The same holds for phase retention versus restart across a pause, the polarity and mode combinations, and the data captured through either path.

// File: rtl/spi_clk_profile_pkg.sv
package spi_clk_profile_pkg;

  localparam int unsigned DEF_ACC_W     = 12;
  localparam int unsigned DEF_TICK_BITS = 10;
  localparam int unsigned DEF_WORD_W    = 14;
  localparam int unsigned DEF_SYNC      = 2;

  // A half-period tick is due when the low tick_bits of the phase plus the
  // word reach the next multiple of 2**tick_bits.
  function automatic logic tick_due(input int unsigned low_phase,
                                    input int unsigned word,
                                    input int unsigned tick_bits);
    return (low_phase + word) >= (32'd1 << tick_bits);
  endfunction

  // Pick the edge event that a rising-select bit refers to.
  function automatic logic pick_edge(input logic use_leading,
                                     input logic leading_ev,
                                     input logic trailing_ev);
    return use_leading ? leading_ev : trailing_ev;
  endfunction

endpackage

// File: rtl/sclk_phase_accum.sv
module sclk_phase_accum
  import spi_clk_profile_pkg::*;
#(
  parameter int unsigned ACC_W     = DEF_ACC_W,
  parameter int unsigned TICK_BITS = DEF_TICK_BITS,
  parameter int unsigned WORD_W    = DEF_WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [WORD_W-1:0] word,
  input  logic              restart_loop,
  output logic              tick,
  output logic              phase_q,
  output logic              leading_ev,
  output logic              trailing_ev
);

  logic             en_q;
  logic             start;
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] base;
  logic [ACC_W-1:0] acc_nxt;

  assign start   = enable & ~en_q;
  assign base    = (start && restart_loop) ? '0 : acc_q;
  assign acc_nxt = base + ACC_W'(word);
  assign tick    = enable & tick_due(int'(base[TICK_BITS-1:0]), int'(word), TICK_BITS);

  assign leading_ev  = tick & ~phase_q;
  assign trailing_ev = tick & phase_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      acc_q   <= '0;
      phase_q <= 1'b0;
    end else begin
      en_q <= enable;
      if (enable) begin
        acc_q <= acc_nxt;
        if (tick) phase_q <= ~phase_q;
      end else begin
        phase_q <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/sclk_strobe_select.sv
module sclk_strobe_select
  import spi_clk_profile_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = DEF_SYNC
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic launch_rise,
  input  logic latch_rise,
  input  logic async_in,
  input  logic leading_ev,
  input  logic trailing_ev,
  output logic launch_pulse,
  output logic sample_pulse,
  output logic sample_event,
  output logic async_cap_ev
);

  logic                   launch_event;
  logic                   smp_q;
  logic [SYNC_STAGES-1:0] dly_q;

  assign launch_event = pick_edge(launch_rise, leading_ev, trailing_ev);
  assign sample_event = pick_edge(latch_rise, leading_ev, trailing_ev);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      launch_pulse <= 1'b0;
      smp_q        <= 1'b0;
    end else begin
      launch_pulse <= launch_event;
      smp_q        <= sample_event;
    end
  end

  generate
    if (SYNC_STAGES == 1) begin : g_one_stage
      always_ff @(posedge clk) begin
        if (!rst_n)       dly_q <= '0;
        else if (!enable) dly_q <= '0;
        else              dly_q <= sample_event;
      end
      assign async_cap_ev = sample_event;
    end else begin : g_multi_stage
      always_ff @(posedge clk) begin
        if (!rst_n)       dly_q <= '0;
        else if (!enable) dly_q <= '0;
        else              dly_q <= {dly_q[SYNC_STAGES-2:0], sample_event};
      end
      assign async_cap_ev = enable & dly_q[SYNC_STAGES-2];
    end
  endgenerate

  assign sample_pulse = async_in ? dly_q[SYNC_STAGES-1] : smp_q;

endmodule

// File: rtl/sdi_capture.sv
module sdi_capture
  import spi_clk_profile_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = DEF_SYNC
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  input  logic sdi,
  input  logic sync_cap_ev,
  input  logic async_cap_ev,
  output logic rx_bit
);

  logic [SYNC_STAGES-1:0] sync_q;

  generate
    if (SYNC_STAGES == 1) begin : g_one_flop
      always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sdi;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], sdi};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_bit <= 1'b0;
    end else if (async_in) begin
      if (async_cap_ev) rx_bit <= sync_q[SYNC_STAGES-1];
    end else if (sync_cap_ev) begin
      rx_bit <= sdi;
    end
  end

endmodule

// File: rtl/spi_clk_profile_gen.sv
module spi_clk_profile_gen
  import spi_clk_profile_pkg::*;
#(
  parameter int unsigned ACC_W       = DEF_ACC_W,
  parameter int unsigned TICK_BITS   = DEF_TICK_BITS,
  parameter int unsigned WORD_W      = DEF_WORD_W,
  parameter int unsigned SYNC_STAGES = DEF_SYNC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [WORD_W-1:0] freq_word,
  input  logic              restart_loop,
  input  logic              cpol,
  input  logic              latch_rise,
  input  logic              launch_rise,
  input  logic              async_in,
  input  logic              sdi,
  output logic              sclk,
  output logic              launch_pulse,
  output logic              sample_pulse,
  output logic              rx_bit
);

  // Internal events, named for the checker.
  logic tick;
  logic phase_q;
  logic leading_ev;
  logic trailing_ev;
  logic sample_event;
  logic async_cap_ev;

  sclk_phase_accum #(
    .ACC_W    (ACC_W),
    .TICK_BITS(TICK_BITS),
    .WORD_W   (WORD_W)
  ) u_accum (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .word        (freq_word),
    .restart_loop(restart_loop),
    .tick        (tick),
    .phase_q     (phase_q),
    .leading_ev  (leading_ev),
    .trailing_ev (trailing_ev)
  );

  sclk_strobe_select #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_strobe (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .launch_rise (launch_rise),
    .latch_rise  (latch_rise),
    .async_in    (async_in),
    .leading_ev  (leading_ev),
    .trailing_ev (trailing_ev),
    .launch_pulse(launch_pulse),
    .sample_pulse(sample_pulse),
    .sample_event(sample_event),
    .async_cap_ev(async_cap_ev)
  );

  sdi_capture #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_capture (
    .clk         (clk),
    .rst_n       (rst_n),
    .async_in    (async_in),
    .sdi         (sdi),
    .sync_cap_ev (sample_event),
    .async_cap_ev(async_cap_ev),
    .rx_bit      (rx_bit)
  );

  assign sclk = cpol ^ phase_q;

endmodule

// File: rtl/spi_clk_profile_gen_sva.sv
module spi_clk_profile_gen_sva #(
  parameter int unsigned WORD_W    = 14,
  parameter int unsigned TICK_BITS = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enable,
  input logic [WORD_W-1:0] freq_word,
  input logic              cpol,
  input logic              launch_rise,
  input logic              async_in,
  input logic              sclk,
  input logic              launch_pulse,
  input logic              sample_pulse,
  input logic              tick,
  input logic              phase_q,
  input logic              sample_event
);

  a_r4_idle_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(enable) |-> (sclk == cpol) && !launch_pulse && !sample_pulse);

  a_r2_phase_moves_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $past(enable) && (phase_q != $past(phase_q)) |-> $past(tick));

  a_r3_fast_word_every_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    $past(enable) && ($past(freq_word) >= WORD_W'(1 << TICK_BITS)) |-> (phase_q != $past(phase_q)));

  a_r7_launch_leading: assert property (@(posedge clk) disable iff (!rst_n)
    launch_pulse && $past(launch_rise) |-> phase_q && !$past(phase_q));

  a_r7_launch_trailing: assert property (@(posedge clk) disable iff (!rst_n)
    launch_pulse && !$past(launch_rise) |-> !phase_q && $past(phase_q));

  a_r9_sync_sample_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    sample_pulse && !async_in && !$past(async_in) |-> (phase_q != $past(phase_q)));

  a_r10_async_two_cycles: assert property (@(posedge clk) disable iff (!rst_n)
    sample_pulse && async_in && $past(async_in) |-> $past(sample_event, 2));

endmodule

bind spi_clk_profile_gen spi_clk_profile_gen_sva #(
  .WORD_W   (WORD_W),
  .TICK_BITS(TICK_BITS)
) u_sva (
  .clk         (clk),
  .rst_n       (rst_n),
  .enable      (enable),
  .freq_word   (freq_word),
  .cpol        (cpol),
  .launch_rise (launch_rise),
  .async_in    (async_in),
  .sclk        (sclk),
  .launch_pulse(launch_pulse),
  .sample_pulse(sample_pulse),
  .tick        (tick),
  .phase_q     (phase_q),
  .sample_event(sample_event)
);

// File: tb/spi_clk_profile_gen_test.sv
module spi_clk_profile_gen_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic [13:0] freq_word = 14'd256;
  logic        restart_loop = 1'b1;
  logic        cpol = 1'b0;
  logic        latch_rise = 1'b1;
  logic        launch_rise = 1'b0;
  logic        async_in = 1'b0;
  logic        sdi = 1'b0;
  logic        sclk, launch_pulse, sample_pulse, rx_bit;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_clk_profile_gen uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .freq_word(freq_word),
    .restart_loop(restart_loop), .cpol(cpol), .latch_rise(latch_rise),
    .launch_rise(launch_rise), .async_in(async_in), .sdi(sdi),
    .sclk(sclk), .launch_pulse(launch_pulse), .sample_pulse(sample_pulse),
    .rx_bit(rx_bit)
  );

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // Scoreboard: expected {sclk, launch, sample, rx} with requirement tag.
  logic [3:0] exp_q[$];
  string      tag_q[$];

  // Behavioural model state.
  int m_phase = 0;
  bit m_ph = 0, m_en_prev = 0, m_lq = 0, m_sq = 0;
  bit m_d1 = 0, m_d2 = 0, m_s1 = 0, m_s2 = 0, m_rx = 0;

  task automatic check_now(string tag, logic [3:0] got, logic [3:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s sclk/launch/sample/rx got=%b exp=%b at %0t", tag, got, exp, $time);
    end
  endtask

  // Driver step: predict the outputs after the coming edge.
  task automatic model_push(string tag);
    bit start, tick, lead, trail, lnow, snow, nrx;
    int base;
    start = enable && !m_en_prev;
    tick = 0;
    if (enable) begin
      base = (start && restart_loop) ? 0 : m_phase;
      tick = ((base % 1024) + int'(freq_word)) >= 1024;
      m_phase = (base + int'(freq_word)) % 4096;
    end
    lead  = tick && !m_ph;
    trail = tick && m_ph;
    if (!enable) m_ph = 0;
    else if (tick) m_ph = !m_ph;
    lnow = launch_rise ? lead : trail;
    snow = latch_rise ? lead : trail;
    nrx = m_rx;
    if (!async_in && snow) nrx = sdi;
    if (async_in && enable && m_d1) nrx = m_s2;
    m_rx = nrx;
    m_d2 = enable && m_d1;
    m_d1 = enable && snow;
    m_s2 = m_s1;
    m_s1 = sdi;
    m_lq = lnow;
    m_sq = snow;
    m_en_prev = enable;
    exp_q.push_back({cpol ^ m_ph, m_lq, async_in ? m_d2 : m_sq, m_rx});
    tag_q.push_back(tag);
  endtask

  task automatic run(string tag, int n);
    for (int i = 0; i < n; i++) begin
      model_push(tag);
      @(negedge clk);
    end
  endtask

  // Monitor: compare one expected item per edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        logic [3:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check_now(t, {sclk, launch_pulse, sample_pulse, rx_bit}, e);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state with both polarities
    check_now("R1", {sclk, launch_pulse, sample_pulse, rx_bit}, 4'b0000);
    cpol = 1'b1;
    #1;
    check_now("R1", {sclk, launch_pulse, sample_pulse, rx_bit}, 4'b1000);
    cpol = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    run("R4", 3);

    // R2: mode 0, word 256 -> 4-cycle half periods
    enable = 1; restart_loop = 1; freq_word = 14'd256; latch_rise = 1; launch_rise = 0; sdi = 1;
    run("R2", 40);
    enable = 0; run("R4", 4);

    // R7: fractional word, launch on leading, sample on trailing
    freq_word = 14'd300; latch_rise = 0; launch_rise = 1; run("R4", 2);
    enable = 1; run("R7", 50);
    enable = 0; run("R4", 4);

    // R6: idle-high polarity
    cpol = 1; freq_word = 14'd512; latch_rise = 1; launch_rise = 0; run("R4", 2);
    enable = 1; run("R6", 30);
    enable = 0; run("R4", 4);

    // R3: words at and beyond the saturation point
    cpol = 0; freq_word = 14'd1500; enable = 1; run("R3", 12);
    enable = 0; run("R4", 3);
    freq_word = 14'd2048; enable = 1; run("R3", 8);
    enable = 0; run("R4", 3);

    // R5: phase retained across a pause, then restarted
    restart_loop = 0; freq_word = 14'd200; enable = 1; run("R5", 7);
    enable = 0; freq_word = 14'd999; run("R4", 6);
    freq_word = 14'd200; enable = 1; run("R5", 20);
    enable = 0; run("R4", 3);
    restart_loop = 1; enable = 1; run("R5", 10);
    enable = 0; run("R4", 3);

    // R9: synchronous capture of both data levels
    freq_word = 14'd400; sdi = 0; enable = 1; run("R9", 20);
    sdi = 1; run("R9", 20);
    enable = 0; run("R4", 3);

    // R10: asynchronous capture with delayed strobe
    async_in = 1; sdi = 0; run("R4", 4);
    enable = 1; run("R10", 30);
    sdi = 1; run("R10", 30);
    enable = 0; run("R11", 4);

    // R8: trailing-edge sampling through the async path
    latch_rise = 0; sdi = 0; enable = 1; run("R8", 30);
    enable = 0; run("R11", 4);

    repeat (2) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      failures++;
      $display("FAIL R2 scoreboard not drained got=%0d exp=0", exp_q.size());
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule